// File: doc/BRIEF.md
# Serial EEPROM Status Register and Write Guard

This block keeps the status byte of a small serial EEPROM and rules on every write that the command path wants to make. The instruction decoder upstream hands it single-cycle strobes: latch-enable, latch-disable, status-write, flag-set and flag-clear. It also supplies an array-write request with a 13-bit word address, the data byte for a status write, and the active-low hardware protect pin. In the same cycle as a request, the block answers with a grant for array writes, a grant for status writes, and a reject strobe. The status byte and the two-bit watchdog period code are always visible at its outputs. The nonvolatile fields are held in ordinary flops that take fixed values at reset.

Write permission depends on three things: a volatile enable latch, a nonvolatile protect-enable bit, and the pin. A two-bit lock code selects how much of the address space is protected: none of it, the top quarter, the top half, or all of it. There is no stream traffic at this block's edge. Every request is a one-cycle strobe that is answered combinationally in the same cycle. There is no back-pressure: a refused request is reported and dropped, never held.

Top module: `eewp_ctrl`

## Requirements
- R1: After reset, status_q is 8'h00, wd_sel is 2'b00, and all grants and the reject strobe are low while no request is present.
- R2: A latch-enable strobe sets the enable latch, which reads in status bit 1 from the next cycle. A latch-disable strobe clears it. Status bit 0 always reads 0.
- R3: While the enable latch is 0, neither an array write nor a status write is granted.
- R4: The lock code in status bits 3:2 protects these ranges. 00 protects nothing. 01 protects 0x1800..0x1FFF. 10 protects 0x1000..0x1FFF. 11 protects every address. An array write to a protected address is never granted.
- R5: With the enable latch set, an array write to an unprotected address is granted, whatever the protect-enable bit and the pin are.
- R6: When the pin is low and the protect-enable bit (status bit 7) is 1, status writes are refused. Otherwise a status write is granted when the enable latch is set.
- R7: A granted status write loads data bit 7 into status bit 7, data bits 5:4 into status bits 5:4, and data bits 3:2 into status bits 3:2. Data bits 6, 1 and 0 have no effect.
- R8: The enable latch reads 0 in the cycle after any granted array write or status write.
- R9: A refused array or status write raises wr_reject for that request cycle only and leaves the whole status byte unchanged.
- R10: A flag-set strobe sets status bit 6 and a flag-clear strobe clears it. If both arrive in the same cycle, the clear wins.
- R11: wd_sel always equals status bits 5:4. The codes are: 00 for the longest period, 01 for the middle period, 10 for the shortest period, and 11 for watchdog disabled.
- R12: In a cycle that has both a latch-enable strobe and a latch-disable strobe or a granted write, the enable latch ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wren | input | 1 | Set-enable-latch strobe |
| cmd_wrdi | input | 1 | Clear-enable-latch strobe |
| cmd_wrsr | input | 1 | Status-write request strobe |
| cmd_setf | input | 1 | Flag-set strobe |
| cmd_clrf | input | 1 | Flag-clear strobe |
| arr_wr_req | input | 1 | Array-write request strobe |
| arr_addr | input | 13 | Word address of the array write |
| sr_wdata | input | 8 | Data byte for a status write |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| arr_wr_grant | output | 1 | Array write allowed (same cycle) |
| sr_wr_grant | output | 1 | Status write allowed (same cycle) |
| wr_reject | output | 1 | Request refused (same cycle) |
| status_q | output | 8 | Status byte: {protect-enable, flag, wd[1:0], lock[1:0], enable latch, 0} |
| wd_sel | output | 2 | Watchdog period code |

## Verification
The grants and the reject strobe are combinational, so they are due in the same cycle as the request. Each change to the status byte is due one rising edge after the strobe that caused it. The driver applies each stimulus on the falling edge and queues the expected grant/reject triple together with the status byte expected after the following rising edge. The monitor compares the triple shortly after that falling edge and the status byte and watchdog code shortly after the rising edge, so every check samples its result exactly where it is due.

// File: rtl/eewp_pkg.sv
`timescale 1ns/1ps
package eewp_pkg;
  localparam int STS_W = 8;

  typedef enum logic [1:0] {
    LOCK_NONE = 2'b00,
    LOCK_QTR  = 2'b01,
    LOCK_HALF = 2'b10,
    LOCK_ALL  = 2'b11
  } lock_e;

  // Field order is the readable byte layout, msb first.
  typedef struct packed {
    logic       wpen;
    logic       flag;
    logic [1:0] wd;
    lock_e      bl;
    logic       wel;
    logic       zero;
  } sts_t;

  localparam logic       RST_WPEN = 1'b0;
  localparam logic [1:0] RST_WD   = 2'b00;
  localparam lock_e      RST_BL   = LOCK_NONE;
endpackage

// File: rtl/eewp_lock_map.sv
`timescale 1ns/1ps
module eewp_lock_map
  import eewp_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  lock_e             bl,
  input  logic [ADDR_W-1:0] addr,
  output logic              locked
);
  localparam int TOP = ADDR_W - 1;

  always_comb begin
    unique case (bl)
      LOCK_NONE: locked = 1'b0;
      LOCK_QTR:  locked = &addr[TOP -: 2];
      LOCK_HALF: locked = addr[TOP];
      default:   locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/eewp_grant.sv
`timescale 1ns/1ps
module eewp_grant (
  input  logic clk,
  input  logic rst_n,
  input  logic wel,
  input  logic wpen,
  input  logic wp_n,
  input  logic locked,
  input  logic arr_req,
  input  logic sr_req,
  output logic arr_ok,
  output logic sr_ok,
  output logic reject
);
  logic rom_mode;

  assign rom_mode = wpen & ~wp_n;
  assign arr_ok   = arr_req & wel & ~locked;
  assign sr_ok    = sr_req & wel & ~rom_mode;
  assign reject   = (arr_req & ~arr_ok) | (sr_req & ~sr_ok);

  // R3
  no_wel_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wel |-> (!arr_ok && !sr_ok));

  // R4
  locked_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !arr_ok);

  // R6
  rom_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && wpen) |-> !sr_ok);

  // R9
  reject_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req && !arr_ok) |-> reject);
endmodule

// File: rtl/eewp_regs.sv
`timescale 1ns/1ps
module eewp_regs
  import eewp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wren,
  input  logic             wrdi,
  input  logic             setf,
  input  logic             clrf,
  input  logic             arr_ok,
  input  logic             sr_ok,
  input  logic [STS_W-1:0] wdata,
  output sts_t             sts
);
  sts_t wd_view;
  logic wel_q, flag_q, wpen_q;
  logic [1:0] wd_q;
  lock_e bl_q;

  assign wd_view = sts_t'(wdata);

  // Volatile enable latch: any clear source beats a same-cycle set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       wel_q <= 1'b0;
    else if (wrdi || arr_ok || sr_ok) wel_q <= 1'b0;
    else if (wren)                    wel_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag_q <= 1'b0;
    else if (clrf) flag_q <= 1'b0;
    else if (setf) flag_q <= 1'b1;
  end

  // Nonvolatile fields, modelled as flops with fixed reset values.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpen_q <= RST_WPEN;
      wd_q   <= RST_WD;
      bl_q   <= RST_BL;
    end else if (sr_ok) begin
      wpen_q <= wd_view.wpen;
      wd_q   <= wd_view.wd;
      bl_q   <= wd_view.bl;
    end
  end

  always_comb begin
    sts      = '0;
    sts.wpen = wpen_q;
    sts.flag = flag_q;
    sts.wd   = wd_q;
    sts.bl   = bl_q;
    sts.wel  = wel_q;
    sts.zero = 1'b0;
  end

  // R8
  wel_autoclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_ok || sr_ok) |=> !wel_q);

  // R9
  nv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_ok |=> ($stable(wpen_q) && $stable(wd_q) && $stable(bl_q)));

  // R10
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clrf |=> !flag_q);

  // R2
  wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wren && !wrdi && !arr_ok && !sr_ok) |=> wel_q);
endmodule

// File: rtl/eewp_ctrl.sv
`timescale 1ns/1ps
module eewp_ctrl
  import eewp_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic              cmd_setf,
  input  logic              cmd_clrf,
  input  logic              arr_wr_req,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic [7:0]        sr_wdata,
  input  logic              wp_n,
  output logic              arr_wr_grant,
  output logic              sr_wr_grant,
  output logic              wr_reject,
  output logic [7:0]        status_q,
  output logic [1:0]        wd_sel
);
  sts_t sts;
  logic locked;

  eewp_lock_map #(.ADDR_W(ADDR_W)) u_lock (
    .bl     (sts.bl),
    .addr   (arr_addr),
    .locked (locked)
  );

  eewp_grant u_grant (
    .clk     (clk),
    .rst_n   (rst_n),
    .wel     (sts.wel),
    .wpen    (sts.wpen),
    .wp_n    (wp_n),
    .locked  (locked),
    .arr_req (arr_wr_req),
    .sr_req  (cmd_wrsr),
    .arr_ok  (arr_wr_grant),
    .sr_ok   (sr_wr_grant),
    .reject  (wr_reject)
  );

  eewp_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wren   (cmd_wren),
    .wrdi   (cmd_wrdi),
    .setf   (cmd_setf),
    .clrf   (cmd_clrf),
    .arr_ok (arr_wr_grant),
    .sr_ok  (sr_wr_grant),
    .wdata  (sr_wdata),
    .sts    (sts)
  );

  assign status_q = sts;
  assign wd_sel   = sts.wd;

  // R9
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> $stable(status_q[7:2]));

  // R5
  open_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr_req && status_q[1] && status_q[3:2] == 2'b00) |-> arr_wr_grant);
endmodule

// File: tb/eewp_ctrl_bench.sv
`timescale 1ns/1ps
module eewp_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_setf = 0, cmd_clrf = 0;
  logic arr_wr_req = 0;
  logic [12:0] arr_addr = '0;
  logic [7:0] sr_wdata = '0;
  logic wp_n = 1'b1;
  logic arr_wr_grant, sr_wr_grant, wr_reject;
  logic [7:0] status_q;
  logic [1:0] wd_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  eewp_ctrl u_eewp_ctrl (.*);

  typedef struct {
    string      req;
    logic       ea, es, er;
    logic [7:0] st;
  } exp_t;
  exp_t sb[$];

  logic m_wel = 0, m_flag = 0, m_wpen = 0;
  logic [1:0] m_wd = 0, m_bl = 0;

  function automatic logic in_lock(logic [12:0] a, logic [1:0] bl);
    case (bl)
      2'b00: return 1'b0;
      2'b01: return a >= 13'h1800;
      2'b10: return a >= 13'h1000;
      default: return 1'b1;
    endcase
  endfunction

  task automatic step(string tag, logic wren, logic wrdi, logic wrsr, logic setf,
                      logic clrf, logic req, logic [12:0] addr, logic [7:0] d, logic wp);
    exp_t e;
    @(negedge clk);
    cmd_wren = wren; cmd_wrdi = wrdi; cmd_wrsr = wrsr; cmd_setf = setf;
    cmd_clrf = clrf; arr_wr_req = req; arr_addr = addr; sr_wdata = d; wp_n = wp;
    e.req = tag;
    e.ea = req & m_wel & ~in_lock(addr, m_bl);
    e.es = wrsr & m_wel & ~(m_wpen & ~wp);
    e.er = (req & ~e.ea) | (wrsr & ~e.es);
    if (e.es) begin m_wpen = d[7]; m_wd = d[5:4]; m_bl = d[3:2]; end
    if (clrf) m_flag = 0; else if (setf) m_flag = 1;
    if (wrdi | e.ea | e.es) m_wel = 0; else if (wren) m_wel = 1;
    e.st = {m_wpen, m_flag, m_wd, m_bl, m_wel, 1'b0};
    sb.push_back(e);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 13'h0, 8'h00, wp_n);
  endtask

  task automatic arr_wr(string tag, logic [12:0] a, logic wp);
    step(tag, 0, 0, 0, 0, 0, 1, a, 8'h00, wp);
  endtask

  task automatic wren(string tag);
    step(tag, 1, 0, 0, 0, 0, 0, 13'h0, 8'h00, wp_n);
  endtask

  task automatic wrsr(string tag, logic [7:0] d, logic wp);
    step(tag, 0, 0, 1, 0, 0, 0, 13'h0, d, wp);
  endtask

  // Monitor: combinational results just after the drive edge, state after the clock edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() != 0) begin
        exp_t e;
        e = sb[0];
        checks++;
        if ({arr_wr_grant, sr_wr_grant, wr_reject} !== {e.ea, e.es, e.er}) begin
          errors++;
          $display("FAIL %s grants/reject: got %b expected %b", e.req,
                   {arr_wr_grant, sr_wr_grant, wr_reject}, {e.ea, e.es, e.er});
        end
        @(posedge clk);
        #1;
        checks++;
        if (status_q !== e.st) begin
          errors++;
          $display("FAIL %s/R11 status: got %h expected %h", e.req, status_q, e.st);
        end
        checks++;
        if (wd_sel !== e.st[5:4]) begin
          errors++;
          $display("FAIL R11 wd_sel: got %b expected %b", wd_sel, e.st[5:4]);
        end
        void'(sb.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (status_q !== 8'h00 || wd_sel !== 2'b00 || arr_wr_grant || sr_wr_grant || wr_reject) begin
      errors++;
      $display("FAIL R1 reset: got %h/%b expected 00/00", status_q, wd_sel);
    end
    idle("R1");
    arr_wr("R3", 13'h0010, 1);
    wrsr("R3", 8'hBC, 1);
    wren("R2");
    step("R2", 0, 1, 0, 0, 0, 0, 13'h0, 8'h00, 1);
    wren("R2");
    arr_wr("R5", 13'h1FFF, 1);
    idle("R8");
    wren("R2");
    wrsr("R7", 8'h57, 1);
    wren("R2");
    arr_wr("R4", 13'h1800, 1);
    arr_wr("R9", 13'h1FFF, 0);
    arr_wr("R5", 13'h17FF, 1);
    wren("R2");
    wrsr("R7", 8'h28, 1);
    wren("R2");
    arr_wr("R4", 13'h1000, 1);
    arr_wr("R5", 13'h0FFF, 1);
    wren("R2");
    wrsr("R7", 8'hBC, 1);
    wren("R2");
    arr_wr("R4", 13'h0000, 1);
    wrsr("R6", 8'h00, 0);
    wrsr("R6", 8'h80, 1);
    wren("R2");
    wrsr("R6", 8'hC0, 0);
    arr_wr("R5", 13'h0abc, 0);
    wren("R2");
    wrsr("R6", 8'h80, 1);
    wren("R2");
    arr_wr("R5", 13'h1FFF, 0);
    step("R10", 0, 0, 0, 1, 0, 0, 13'h0, 8'h00, 1);
    step("R10", 0, 0, 0, 1, 1, 0, 13'h0, 8'h00, 1);
    step("R10", 0, 0, 0, 1, 0, 0, 13'h0, 8'h00, 1);
    step("R10", 0, 0, 0, 0, 1, 0, 13'h0, 8'h00, 1);
    step("R12", 1, 1, 0, 0, 0, 0, 13'h0, 8'h00, 1);
    wren("R2");
    step("R12", 1, 0, 0, 0, 0, 1, 13'h0123, 8'h00, 1);
    wren("R2");
    wrsr("R7", 8'h30, 1);
    idle("R11");
    idle("R11");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule